// File: doc/BRIEF.md
# Lane-Confined Byte Shift Unit

This block moves the bytes of a wide vector toward the more significant end by a whole number of byte positions, with every 128-bit lane treated as a separate shifter. Bytes never travel from one lane into the next. The byte positions left empty at the bottom of a lane are filled with zeros. If the count asks for more positions than a lane holds, that lane comes out as all zeros.

A 2-bit selector picks one of four operating modes. The mode decides two things: which input supplies the low lane, and what happens to the upper lanes. The upper lanes can keep their previous destination contents, be forced to zero, or be shifted by the same count as the low lane.

The result and a valid flag are registered. Both appear one clock after an accepted input.

Top module: `lane_byte_shifter`

## Requirements
- R1: For a count from 0 to 15, output byte b of a shifted lane equals input byte b-count of the same lane when b >= count, and zero otherwise. Byte 0 is bits [7:0] of the lane.
- R2: For any count from 16 to 255, every lane that would be shifted comes out all zero.
- R3: With mode 2'b10 (wide), both 128-bit lanes of `src_data` are shifted by the same count, and no byte of the low lane appears in the high lane.
- R4: With mode 2'b01 (narrow, non-destructive), the low lane is `src_data[127:0]` shifted, and `out_data[255:128]` is zero.
- R5: With mode 2'b00 (narrow, destructive), the low lane is `dst_prev[127:0]` shifted, `out_data[255:128]` equals `dst_prev[255:128]`, and `src_data` has no effect on the result.
- R6: With mode 2'b11 (reserved), the whole result is zero.
- R7: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. `out_data` carries that input's result in the same cycle.
- R8: While `in_valid` is low, `out_data` holds its last value.
- R9: A synchronous active-high `rst` clears `out_valid` and `out_data`, and it overrides `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input operands are valid this cycle |
| src_data | input | 256 | Source vector for the non-destructive and wide modes |
| dst_prev | input | 256 | Previous destination value; this is the operand in destructive mode |
| shift_cnt | input | 8 | Byte shift count |
| mode | input | 2 | 00 destructive, 01 narrow, 10 wide, 11 reserved |
| out_valid | output | 1 | Result valid |
| out_data | output | 256 | Registered result |

## Verification
Every count from 0 to 255 is run in every mode against two operand pairs.

The first pair uses a byte-index ramp in `src_data` and a distinct ramp in `dst_prev`. With it, each output byte shows which input byte it came from. This tells a wrong shift distance apart from a wrong operand choice, and it shows a lane crossing as a low-lane value turning up in the high lane.

The second pair sets `src_data` to all ones. Any zero fill that is missing, or any clear above 15 that fails to happen, stands out clearly.

Directed cases cover three further points: reset winning over a valid input, the result holding while input is idle, and destructive mode ignoring changes to `src_data`.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
   typedef enum logic [1:0] {
      LBS_DESTR  = 2'b00,
      LBS_NARROW = 2'b01,
      LBS_WIDE   = 2'b10,
      LBS_RSVD   = 2'b11
   } lbs_mode_e;
endpackage

// File: rtl/lbs_lane_shifter.sv
// One lane: log-depth byte shifter with a clear on oversize counts.
module lbs_lane_shifter #(
   parameter int LANE_BYTES = 16,
   parameter int CNT_W      = 8
) (
   input  logic [LANE_BYTES*8-1:0] lane_in,
   input  logic [CNT_W-1:0]        cnt,
   output logic [LANE_BYTES*8-1:0] lane_out
);
   localparam int LANE_W = LANE_BYTES * 8;
   localparam int STAGES = $clog2(LANE_BYTES);

   if ((1 << STAGES) != LANE_BYTES) begin : g_bad_lane
      $error("LANE_BYTES must be a power of two");
   end
   if (CNT_W <= STAGES) begin : g_bad_cnt
      $error("CNT_W must exceed log2(LANE_BYTES)");
   end

   logic [LANE_W-1:0] stage [STAGES+1];
   logic              over;

   assign stage[0] = lane_in;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      localparam int SH = 8 << s;
      assign stage[s+1] = cnt[s] ? (stage[s] << SH) : stage[s];
   end

   assign over     = |cnt[CNT_W-1:STAGES];
   assign lane_out = over ? '0 : stage[STAGES];
endmodule

// File: rtl/lbs_compose.sv
// Builds the full-width result from shifted lanes according to the mode.
module lbs_compose
   import lbs_pkg::*;
#(
   parameter int LANE_BYTES = 16,
   parameter int NUM_LANES  = 2
) (
   input  logic [LANE_BYTES*8*NUM_LANES-1:0] shifted,
   input  logic [LANE_BYTES*8*NUM_LANES-1:0] dst_prev,
   input  lbs_mode_e                         mode,
   output logic [LANE_BYTES*8*NUM_LANES-1:0] result
);
   localparam int LANE_W = LANE_BYTES * 8;

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      if (l == 0) begin : g_low
         assign result[LANE_W-1:0] = (mode == LBS_RSVD) ? '0 : shifted[LANE_W-1:0];
      end else begin : g_high
         always_comb begin
            unique case (mode)
               LBS_DESTR: result[l*LANE_W +: LANE_W] = dst_prev[l*LANE_W +: LANE_W];
               LBS_WIDE:  result[l*LANE_W +: LANE_W] = shifted[l*LANE_W +: LANE_W];
               default:   result[l*LANE_W +: LANE_W] = '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/lane_byte_shifter.sv
module lane_byte_shifter
   import lbs_pkg::*;
#(
   parameter int LANE_BYTES = 16,
   parameter int NUM_LANES  = 2,
   parameter int CNT_W      = 8
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              in_valid,
   input  logic [LANE_BYTES*8*NUM_LANES-1:0] src_data,
   input  logic [LANE_BYTES*8*NUM_LANES-1:0] dst_prev,
   input  logic [CNT_W-1:0]                  shift_cnt,
   input  logic [1:0]                        mode,
   output logic                              out_valid,
   output logic [LANE_BYTES*8*NUM_LANES-1:0] out_data
);
   localparam int LANE_W = LANE_BYTES * 8;
   localparam int DATA_W = LANE_W * NUM_LANES;

   if (NUM_LANES < 1) begin : g_bad_lanes
      $error("NUM_LANES must be at least one");
   end

   lbs_mode_e         mode_e;
   logic [DATA_W-1:0] operand;
   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] result;

   assign mode_e  = lbs_mode_e'(mode);
   assign operand = (mode_e == LBS_DESTR) ? dst_prev : src_data;

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      lbs_lane_shifter #(
         .LANE_BYTES(LANE_BYTES),
         .CNT_W     (CNT_W)
      ) u_lane (
         .lane_in (operand[l*LANE_W +: LANE_W]),
         .cnt     (shift_cnt),
         .lane_out(shifted[l*LANE_W +: LANE_W])
      );
   end

   lbs_compose #(
      .LANE_BYTES(LANE_BYTES),
      .NUM_LANES (NUM_LANES)
   ) u_compose (
      .shifted (shifted),
      .dst_prev(dst_prev),
      .mode    (mode_e),
      .result  (result)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= result;
      end
   end
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
   parameter int LANE_BYTES = 16,
   parameter int NUM_LANES  = 2,
   parameter int CNT_W      = 8
) (
   input logic                              clk,
   input logic                              rst,
   input logic                              in_valid,
   input logic [LANE_BYTES*8*NUM_LANES-1:0] dst_prev,
   input logic [CNT_W-1:0]                  shift_cnt,
   input logic [1:0]                        mode,
   input logic                              out_valid,
   input logic [LANE_BYTES*8*NUM_LANES-1:0] out_data
);
   localparam int LANE_W = LANE_BYTES * 8;
   localparam int DATA_W = LANE_W * NUM_LANES;

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R7
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid); // R7
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_data)); // R8
   AST_BIG_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == 2'b10 && shift_cnt >= CNT_W'(LANE_BYTES)) |=> out_data == '0); // R2
   AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == 2'b01) |=> out_data[DATA_W-1:LANE_W] == '0); // R4
   AST_DESTR_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == 2'b00) |=> out_data[DATA_W-1:LANE_W] == $past(dst_prev[DATA_W-1:LANE_W])); // R5
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == 2'b11) |=> out_data == '0); // R6
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!out_valid && out_data == '0)); // R9
endmodule

bind lane_byte_shifter lbs_checker #(
   .LANE_BYTES(LANE_BYTES),
   .NUM_LANES (NUM_LANES),
   .CNT_W     (CNT_W)
) i_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .dst_prev (dst_prev),
   .shift_cnt(shift_cnt),
   .mode     (mode),
   .out_valid(out_valid),
   .out_data (out_data)
);

// File: tb/test_lane_byte_shifter.sv
`timescale 1ns/1ps
module test_lane_byte_shifter;
   localparam int NB = 32;
   localparam int W  = NB * 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [W-1:0]  src_data = '0;
   logic [W-1:0]  dst_prev = '0;
   logic [7:0]    shift_cnt = '0;
   logic [1:0]    mode = '0;
   logic          out_valid;
   logic [W-1:0]  out_data;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   lane_byte_shifter i_lane_byte_shifter (
      .clk(clk), .rst(rst), .in_valid(in_valid), .src_data(src_data),
      .dst_prev(dst_prev), .shift_cnt(shift_cnt), .mode(mode),
      .out_valid(out_valid), .out_data(out_data)
   );

   // {mode, count} directed table
   localparam logic [9:0] VEC [10] = '{
      {2'b10, 8'd0},  {2'b10, 8'd1},  {2'b10, 8'd15}, {2'b10, 8'd16},
      {2'b01, 8'd7},  {2'b01, 8'd200},{2'b00, 8'd3},  {2'b00, 8'd15},
      {2'b11, 8'd0},  {2'b11, 8'd9}
   };

   function automatic logic [W-1:0] model(input logic [W-1:0] s, input logic [W-1:0] d,
                                          input int cnt, input logic [1:0] m);
      logic [W-1:0] r = '0;
      logic [W-1:0] op = (m == 2'b00) ? d : s;
      for (int b = 0; b < NB; b++) begin
         int lane = b / 16;
         int pos  = b % 16;
         logic [7:0] v = 8'h00;
         if (lane == 0 || m == 2'b10) begin
            if (m != 2'b11 && cnt < 16 && pos >= cnt) v = op[(lane*16 + pos - cnt)*8 +: 8];
         end else if (m == 2'b00) begin
            v = d[b*8 +: 8];
         end
         r[b*8 +: 8] = v;
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [W-1:0] s, input logic [W-1:0] d,
                        input int cnt, input logic [1:0] m, input string req);
      logic [W-1:0] exp = model(s, d, cnt, m);
      @(negedge clk);
      src_data = s; dst_prev = d; shift_cnt = 8'(cnt); mode = m; in_valid = 1'b1;
      @(negedge clk);
      check(out_valid === 1'b1, {req, " R7 valid"}, W'(out_valid), W'(1));
      check(out_data === exp, req, out_data, exp);
   endtask

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [W-1:0] ramp_s, ramp_d, ones, alt, held;
      for (int b = 0; b < NB; b++) begin
         ramp_s[b*8 +: 8] = 8'(b + 1);
         ramp_d[b*8 +: 8] = 8'(8'hA0 + b);
      end
      ones = '1;
      alt  = {NB{8'h5A}};

      // R9: reset overrides a valid input
      in_valid = 1'b1; src_data = ones; mode = 2'b10;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_valid === 1'b0, "R9 reset valid", W'(out_valid), '0);
      check(out_data === '0, "R9 reset data", out_data, '0);
      rst = 1'b0;

      // Directed table (R1 R2 R3 R4 R5 R6)
      for (int i = 0; i < 10; i++)
         apply(ramp_s, ramp_d, int'(VEC[i][7:0]), VEC[i][9:8], "R1 table");

      // Sweep all counts and modes: R1 R2 R3 R4 R5 R6
      for (int m = 0; m < 4; m++) begin
         for (int c = 0; c < 256; c++) begin
            apply(ramp_s, ramp_d, c, 2'(m), (c > 15) ? "R2 sweep" : "R1 R3 sweep");
            apply(ones, alt, c, 2'(m), (m == 0) ? "R5 sweep" : "R4 R6 sweep");
         end
      end

      // R5: src has no effect in destructive mode
      apply(ones, ramp_d, 4, 2'b00, "R5 src ignored a");
      apply('0, ramp_d, 4, 2'b00, "R5 src ignored b");

      // R8: hold while idle, R7 valid drops
      apply(ramp_s, ramp_d, 2, 2'b10, "R8 setup");
      held = out_data;
      @(negedge clk);
      in_valid = 1'b0; src_data = ones; dst_prev = alt; shift_cnt = 8'd0; mode = 2'b01;
      @(negedge clk);
      check(out_valid === 1'b0, "R7 valid low when idle", W'(out_valid), '0);
      check(out_data === held, "R8 hold", out_data, held);
      @(negedge clk);
      check(out_data === held, "R8 hold second cycle", out_data, held);

      // R9: reset mid-run clears output
      rst = 1'b1;
      @(negedge clk);
      check(out_data === '0 && out_valid === 1'b0, "R9 reset mid-run", out_data, '0);
      rst = 1'b0;

      finish_run();
   end
endmodule